// File: doc/BRIEF.md
# Macroblock Deblocking Edge Scheduler

This block orders the edge-filtering work for a single macroblock in a deblocking filter. A macroblock is a 16x16 luma matrix plus one 8x8 matrix for each of the two chroma components. It is cut into twenty-four 4x4 blocks. The luma blocks are numbered 0 to 15 as 4*row+col. Blue-difference chroma (Cb) blocks are 16 + 2*row + col, and red-difference chroma (Cr) blocks are 20 + 2*row + col. Each block has a left boundary, which is a vertical edge segment, and a top boundary, which is a horizontal edge segment. Each segment carries a filtering strength from 0 to 4, and segments are indexed by the number of the block on their q side.

A start pulse captures both strength vectors and the two flags that say whether the left and upper neighbour macroblocks are present. The scheduler then walks 48 segment slots: first all 24 vertical slots, then all 24 horizontal slots. For every segment that needs filtering it offers a descriptor on a valid/ready handshake. The descriptor gives the edge direction, the edge index, the q-side and p-side block numbers, whether the p block lies in a neighbour macroblock, the component, and how many pixels per side the filter may change. A one-cycle done pulse closes the sequence. The pixel arithmetic and the derivation of strengths belong to other blocks.

Top module: `mb_edge_sequencer`

## Requirements
- R1: After reset, descValid and done are both low.
- R2: Slots are issued in a fixed order: every vertical slot before any horizontal slot. Within a direction, the luma edges come first at offsets 0, 4, 8 and 12, then two Cb edges, then two Cr edges. Along an edge, segments go top to bottom (vertical) or left to right (horizontal). descEdge numbers the edges 0..7 in this order and descQBlk carries the q block number.
- R3: For an edge at column or row 0 of its component, descPExt is 1 and descPBlk is the adjacent block in the neighbour macroblock. Vertical edges use q+3 for luma and q+1 for chroma. Horizontal edges use q+12 for luma and q+2 for chroma. For every other edge, descPExt is 0 and descPBlk is q-1 (vertical), q-4 (horizontal luma) or q-2 (horizontal chroma).
- R4: A segment of strength 0 produces no descriptor.
- R5: descPixels is 2 for strengths 1 to 3, and 3 for strengths 4 to 7.
- R6: When leftAvail was low at start, no vertical edge at column 0 of any component is issued. When topAvail was low, no horizontal edge at row 0 is issued.
- R7: Strengths and neighbour flags are taken in the cycle start is sampled while idle. Later changes to them, and start pulses during a sequence, have no effect on that sequence.
- R8: While descValid is high and descReady is low, descValid stays high and every descriptor field holds its value.
- R9: done is high for exactly one cycle: the cycle after the edge on which the last slot retires, whether that slot was accepted or skipped. done also follows a sequence in which every slot is skipped.
- R10: descDir is 0 for vertical and 1 for horizontal. descComp is 0 for luma, 1 for Cb and 2 for Cr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a macroblock sequence (ignored while busy) |
| leftAvail | input | 1 | Left neighbour macroblock present |
| topAvail | input | 1 | Upper neighbour macroblock present |
| vertStrength | input | 72 | Strength of each block's left edge, 3 bits at 3*q |
| horzStrength | input | 72 | Strength of each block's top edge, 3 bits at 3*q |
| descValid | output | 1 | Descriptor offered |
| descReady | input | 1 | Descriptor taken by the consumer |
| descDir | output | 1 | 0 vertical, 1 horizontal |
| descEdge | output | 3 | Edge index within the direction |
| descQBlk | output | 5 | q-side block number |
| descPBlk | output | 5 | p-side block number |
| descPExt | output | 1 | p block lies in a neighbour macroblock |
| descComp | output | 2 | 0 luma, 1 Cb, 2 Cr |
| descPixels | output | 2 | Pixels per side that may change |
| done | output | 1 | Sequence finished |

## Verification
The hardest case to reach from the ports is a final slot that retires under back-pressure, while a stray start pulse and changed strength inputs arrive mid-sequence. The done pulse must then line up with that final acceptance, and the stray pulse must leave the captured descriptor list unchanged. The bench reaches this state in two runs. One holds descReady in a repeating low pattern. The other overwrites every strength and flag input right after start and fires a second start a few cycles later. Separate runs clear one or both neighbour flags, and use strengths of 0 and above 4, so that the outer-edge gating and the pixel mapping are each isolated.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_BLOCKS    = 24;
  localparam int SLOTS_PER_DIR = 24;
  localparam int NUM_SLOTS     = 2 * SLOTS_PER_DIR;
  localparam int STEP_W        = $clog2(NUM_SLOTS);
  localparam int BLK_W         = $clog2(NUM_BLOCKS);

  typedef enum logic [1:0] {
    COMP_LUMA = 2'd0,
    COMP_CB   = 2'd1,
    COMP_CR   = 2'd2
  } comp_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrl_strobe_t;

  typedef struct packed {
    logic             dir;
    logic [2:0]       edgeIdx;
    logic [BLK_W-1:0] qBlk;
    logic [BLK_W-1:0] pBlk;
    logic             pExt;
    comp_e            comp;
    logic [1:0]       pixels;
  } edge_desc_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slotActive,
  input  logic              descReady,
  output ctrl_strobe_t      strobe,
  output logic [STEP_W-1:0] step,
  output logic              descValid,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_SLOTS - 1);

  logic running;
  logic lastSlot;

  always_comb begin
    lastSlot       = (step == LAST_STEP);
    descValid      = running & slotActive;
    strobe.load    = start & ~running;
    strobe.advance = running & (~slotActive | descReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.advance & lastSlot;
      if (strobe.load) begin
        running <= 1'b1;
        step    <= '0;
      end else if (strobe.advance) begin
        if (lastSlot) begin
          running <= 1'b0;
          step    <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int STR_W    = 3,
  parameter int FULL_STR = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobe_t                strobe,
  input  logic [NUM_BLOCKS*STR_W-1:0] vertStrength,
  input  logic [NUM_BLOCKS*STR_W-1:0] horzStrength,
  input  logic                        leftAvail,
  input  logic                        topAvail,
  input  logic [STEP_W-1:0]           step,
  output logic                        slotActive,
  output edge_desc_t                  desc
);
  localparam logic [STR_W-1:0] STRONG = STR_W'(FULL_STR);
  localparam logic [BLK_W-1:0] CB_BASE = BLK_W'(16);
  localparam logic [BLK_W-1:0] CR_BASE = BLK_W'(20);

  logic [STR_W-1:0] vStr [NUM_BLOCKS];
  logic [STR_W-1:0] hStr [NUM_BLOCKS];
  logic             leftQ, topQ;

  // Capture the whole job at start so the caller may move on.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ <= 1'b0;
      topQ  <= 1'b0;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        vStr[b] <= '0;
        hStr[b] <= '0;
      end
    end else if (strobe.load) begin
      leftQ <= leftAvail;
      topQ  <= topAvail;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        vStr[b] <= vertStrength[b*STR_W +: STR_W];
        hStr[b] <= horzStrength[b*STR_W +: STR_W];
      end
    end
  end

  logic             isHorz;
  logic [4:0]       idx;
  logic             isCr;
  logic [BLK_W-1:0] base;
  logic [BLK_W-1:0] qBlk;
  logic [BLK_W-1:0] pBlk;
  logic [2:0]       edgeIdx;
  logic             outer;
  comp_e            comp;
  logic [STR_W-1:0] sel;

  // Slot index to block geometry.
  always_comb begin
    isHorz  = (step >= STEP_W'(SLOTS_PER_DIR));
    idx     = isHorz ? 5'(step - STEP_W'(SLOTS_PER_DIR)) : 5'(step);
    isCr    = idx[2];
    base    = isCr ? CR_BASE : CB_BASE;
    qBlk    = '0;
    pBlk    = '0;
    edgeIdx = '0;
    outer   = 1'b0;
    comp    = COMP_LUMA;
    if (!idx[4]) begin
      edgeIdx = {1'b0, idx[3:2]};
      outer   = (idx[3:2] == 2'd0);
      if (!isHorz) begin
        qBlk = {idx[1:0], idx[3:2]};
        pBlk = outer ? qBlk + BLK_W'(3) : qBlk - BLK_W'(1);
      end else begin
        qBlk = idx;
        pBlk = outer ? qBlk + BLK_W'(12) : qBlk - BLK_W'(4);
      end
    end else begin
      comp    = isCr ? COMP_CR : COMP_CB;
      edgeIdx = {1'b1, isCr, idx[1]};
      outer   = ~idx[1];
      if (!isHorz) begin
        qBlk = base + BLK_W'({idx[0], idx[1]});
        pBlk = outer ? qBlk + BLK_W'(1) : qBlk - BLK_W'(1);
      end else begin
        qBlk = base + BLK_W'(idx[1:0]);
        pBlk = outer ? qBlk + BLK_W'(2) : qBlk - BLK_W'(2);
      end
    end
  end

  always_comb begin
    sel         = isHorz ? hStr[qBlk] : vStr[qBlk];
    slotActive  = (sel != '0) && (!outer || (isHorz ? topQ : leftQ));
    desc.dir     = isHorz;
    desc.edgeIdx = edgeIdx;
    desc.qBlk    = qBlk;
    desc.pBlk    = pBlk;
    desc.pExt    = outer;
    desc.comp    = comp;
    desc.pixels  = (sel >= STRONG) ? 2'd3 : 2'd2;
  end
endmodule

// File: rtl/mb_edge_sequencer.sv
module mb_edge_sequencer
  import sched_pkg::*;
#(
  parameter int STR_W    = 3,
  parameter int FULL_STR = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        leftAvail,
  input  logic                        topAvail,
  input  logic [NUM_BLOCKS*STR_W-1:0] vertStrength,
  input  logic [NUM_BLOCKS*STR_W-1:0] horzStrength,
  output logic                        descValid,
  input  logic                        descReady,
  output logic                        descDir,
  output logic [2:0]                  descEdge,
  output logic [BLK_W-1:0]            descQBlk,
  output logic [BLK_W-1:0]            descPBlk,
  output logic                        descPExt,
  output logic [1:0]                  descComp,
  output logic [1:0]                  descPixels,
  output logic                        done
);
  ctrl_strobe_t      strobe;
  logic [STEP_W-1:0] step;
  logic              slotActive;
  edge_desc_t        desc;

  sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .slotActive (slotActive),
    .descReady  (descReady),
    .strobe     (strobe),
    .step       (step),
    .descValid  (descValid),
    .done       (done)
  );

  sched_datapath #(.STR_W(STR_W), .FULL_STR(FULL_STR)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .vertStrength (vertStrength),
    .horzStrength (horzStrength),
    .leftAvail    (leftAvail),
    .topAvail     (topAvail),
    .step         (step),
    .slotActive   (slotActive),
    .desc         (desc)
  );

  assign descDir    = desc.dir;
  assign descEdge   = desc.edgeIdx;
  assign descQBlk   = desc.qBlk;
  assign descPBlk   = desc.pBlk;
  assign descPExt   = desc.pExt;
  assign descComp   = desc.comp;
  assign descPixels = desc.pixels;
endmodule

// File: rtl/mb_edge_sequencer_chk.sv
module mb_edge_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       leftAvail,
  input logic       topAvail,
  input logic       descValid,
  input logic       descReady,
  input logic       descDir,
  input logic [2:0] descEdge,
  input logic [4:0] descQBlk,
  input logic [4:0] descPBlk,
  input logic       descPExt,
  input logic [1:0] descComp,
  input logic [1:0] descPixels,
  input logic       done
);
  logic        active, leftCap, topCap, sawHorz;
  logic [18:0] descVec;

  assign descVec = {descDir, descEdge, descQBlk, descPBlk, descPExt, descComp, descPixels};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      leftCap <= 1'b0;
      topCap  <= 1'b0;
      sawHorz <= 1'b0;
    end else if (start && (!active || done)) begin
      active  <= 1'b1;
      leftCap <= leftAvail;
      topCap  <= topAvail;
      sawHorz <= 1'b0;
    end else begin
      if (done) active <= 1'b0;
      if (descValid && descReady && descDir) sawHorz <= 1'b1;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descVec)); // R8
  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> (descPixels == 2'd2 || descPixels == 2'd3)); // R5
  AST_VERT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descDir |-> !sawHorz); // R2
  AST_LEFT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descDir && descPExt |-> leftCap); // R6
  AST_TOP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descDir && descPExt |-> topCap); // R6
  AST_EXT_OUTER: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descPExt |-> (descEdge == 3'd0 || descEdge == 3'd4 || descEdge == 3'd6)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !descValid); // R9
endmodule

bind mb_edge_sequencer mb_edge_sequencer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .leftAvail  (leftAvail),
  .topAvail   (topAvail),
  .descValid  (descValid),
  .descReady  (descReady),
  .descDir    (descDir),
  .descEdge   (descEdge),
  .descQBlk   (descQBlk),
  .descPBlk   (descPBlk),
  .descPExt   (descPExt),
  .descComp   (descComp),
  .descPixels (descPixels),
  .done       (done)
);

// File: tb/tb_mb_edge_sequencer.sv
module tb_mb_edge_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        leftAvail = 1'b0, topAvail = 1'b0;
  logic [71:0] vertStrength = '0, horzStrength = '0;
  logic        descValid, descReady = 1'b0;
  logic        descDir, descPExt, done;
  logic [2:0]  descEdge;
  logic [4:0]  descQBlk, descPBlk;
  logic [1:0]  descComp, descPixels;

  int errors = 0;
  int checks = 0;

  int expDir[48], expEdge[48], expQ[48], expP[48], expExt[48], expComp[48], expPix[48];
  int expN;
  int expLastSlot;

  always #4 clk = ~clk;

  mb_edge_sequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .leftAvail(leftAvail), .topAvail(topAvail),
    .vertStrength(vertStrength), .horzStrength(horzStrength),
    .descValid(descValid), .descReady(descReady), .descDir(descDir), .descEdge(descEdge),
    .descQBlk(descQBlk), .descPBlk(descPBlk), .descPExt(descPExt), .descComp(descComp),
    .descPixels(descPixels), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic buildExp(input logic [71:0] vs, input logic [71:0] hs, input logic la, input logic ta);
    int slot;
    slot = 0;
    expN = 0;
    expLastSlot = -1;
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 8; e++) begin
        for (int sg = 0; sg < ((e < 4) ? 4 : 2); sg++) begin
          int q, p, ext, comp, s;
          if (e < 4) begin
            q    = (d == 0) ? 4 * sg + e : 4 * e + sg;
            ext  = (e == 0);
            p    = ext ? ((d == 0) ? q + 3 : q + 12) : ((d == 0) ? q - 1 : q - 4);
            comp = 0;
          end else begin
            int k, bse;
            k    = (e - 4) % 2;
            bse  = (e < 6) ? 16 : 20;
            comp = (e < 6) ? 1 : 2;
            q    = (d == 0) ? bse + 2 * sg + k : bse + 2 * k + sg;
            ext  = (k == 0);
            p    = ext ? ((d == 0) ? q + 1 : q + 2) : ((d == 0) ? q - 1 : q - 2);
          end
          s = (d == 0) ? int'(vs[3*q +: 3]) : int'(hs[3*q +: 3]);
          if (s != 0 && (ext == 0 || ((d == 0) ? la : ta))) begin
            expDir[expN]  = d;
            expEdge[expN] = e;
            expQ[expN]    = q;
            expP[expN]    = p;
            expExt[expN]  = ext;
            expComp[expN] = comp;
            expPix[expN]  = (s >= 4) ? 3 : 2;
            expN++;
            expLastSlot = slot;
          end
          slot++;
        end
      end
    end
  endtask

  // One macroblock run: readyMode 0 = always ready, 1 = stalls; disturb adds a stray start.
  task automatic runCase(input logic [71:0] vs, input logic [71:0] hs, input logic la,
                         input logic ta, input int readyMode, input bit disturb, input string tag);
    int got, cyc;
    bit finished, lastAcc, holdPending;
    logic [18:0] held;
    buildExp(vs, hs, la, ta);
    @(negedge clk);
    vertStrength = vs; horzStrength = hs; leftAvail = la; topAvail = ta;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: inputs change after capture
    vertStrength = ~vs; horzStrength = ~hs; leftAvail = ~la; topAvail = ~ta;
    got = 0; cyc = 0; finished = 0; lastAcc = 0; holdPending = 0; held = '0;
    while (!finished && cyc < 600) begin
      descReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 1);
      start = (disturb && cyc == 4);
      #1;
      if (holdPending) begin
        chk(descValid === 1'b1, "R8 valid held", descValid, 1);
        chk({descDir, descEdge, descQBlk, descPBlk, descPExt, descComp, descPixels} === held,
            "R8 fields held", {descDir, descEdge, descQBlk, descPBlk, descPExt, descComp, descPixels}, held);
        holdPending = 0;
      end
      if (done) begin
        chk(got == expN, {tag, " descriptor count"}, got, expN);
        if (expLastSlot == 47) chk(lastAcc, "R9 done after final accept", lastAcc, 1);
        finished = 1;
      end else if (descValid) begin
        if (got < expN) begin
          chk(descDir == expDir[got][0] && descEdge == 3'(expEdge[got]) && descQBlk == 5'(expQ[got]),
              "R2 order/edge/q", {descDir, descEdge, descQBlk}, (expDir[got] << 8) | (expEdge[got] << 5) | expQ[got]);
          chk(descPBlk == 5'(expP[got]) && descPExt == expExt[got][0], "R3 p block/ext",
              {descPExt, descPBlk}, (expExt[got] << 5) | expP[got]);
          chk(descComp == 2'(expComp[got]), "R10 component", descComp, expComp[got]);
          chk(descPixels == 2'(expPix[got]), "R5 pixels", descPixels, expPix[got]);
        end else begin
          chk(0, {tag, " extra descriptor"}, got + 1, expN);
        end
        if (descReady) begin
          got++;
          lastAcc = 1;
        end else begin
          held = {descDir, descEdge, descQBlk, descPBlk, descPExt, descComp, descPixels};
          holdPending = 1;
          lastAcc = 0;
        end
      end else begin
        lastAcc = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(finished, "R9 done seen", finished, 1);
    #1;
    chk(!done && !descValid, "R9 done single cycle", done, 0);
  endtask

  function automatic logic [71:0] mkStr(input int mul, input int add, input int modv, input int off);
    logic [71:0] v;
    v = '0;
    for (int b = 0; b < 24; b++) v[3*b +: 3] = 3'(((b * mul + add) % modv) + off);
    return v;
  endfunction

  task automatic testReset();
    #1;
    chk(descValid === 1'b0, "R1 valid after reset", descValid, 0);
    chk(done === 1'b0, "R1 done after reset", done, 0);
  endtask

  task automatic testFull();            // all 48 slots active, free flow
    runCase(mkStr(1, 0, 4, 1), mkStr(1, 2, 4, 1), 1'b1, 1'b1, 0, 0, "R2");
  endtask

  task automatic testNoNeighbours();    // outer edges gated
    runCase(mkStr(1, 0, 4, 1), mkStr(1, 1, 4, 1), 1'b0, 1'b0, 0, 0, "R6");
    runCase(mkStr(3, 1, 4, 1), mkStr(1, 3, 4, 1), 1'b0, 1'b1, 0, 0, "R6");
    runCase(mkStr(1, 1, 4, 1), mkStr(3, 0, 4, 1), 1'b1, 1'b0, 0, 0, "R6");
  endtask

  task automatic testSparse();          // zeros skipped, strengths 5..7 saturate
    runCase(mkStr(3, 0, 8, 0), mkStr(5, 2, 8, 0), 1'b1, 1'b1, 0, 0, "R4");
  endtask

  task automatic testBackpressure();
    runCase(mkStr(1, 0, 4, 1), mkStr(1, 2, 4, 1), 1'b1, 1'b1, 1, 0, "R8");
  endtask

  task automatic testStartIgnored();
    runCase(mkStr(5, 1, 5, 0), mkStr(7, 3, 5, 0), 1'b1, 1'b0, 1, 1, "R7");
  endtask

  task automatic testAllZero();
    runCase('0, '0, 1'b1, 1'b1, 0, 0, "R4");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFull();
    testNoNeighbours();
    testSparse();
    testBackpressure();
    testStartIgnored();
    testAllZero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule